// File: doc/BRIEF.md
# Pipelined Nine-Pixel Median Sorter

This block returns the median of a 3x3 pixel neighbourhood. The nine unsigned samples arrive together on one wide bus with a qualifying strobe. A staged network of compare-exchange cells orders them, and the lane that ends up in the centre position is presented as the result with its own strobe. Forming the window, buffering lines and handling image borders are done elsewhere. Any of these that is needed happens before the block.

The network has nine steps. Each step holds only compare-exchange cells that touch disjoint lanes, so the cells in one step are independent. A parameter mask chooses which steps end in a register. With the default mask every step is registered, the latency is nine cycles, and the block accepts a new group on every clock. Only strobe bits carry a reset. Data registers load only when their stage holds a valid group.

Top module: `median9_sorter`

## Requirements
- R1: `in_pix` carries nine unsigned `DATA_W`-bit pixels, with pixel k in bits [k*DATA_W +: DATA_W]. `out_median` is the fifth smallest of the nine, which is the smallest value with more than four of the nine at or below it.
- R2: Comparison is unsigned. A pixel with its top bit set, such as 128 or 255, orders above every pixel with its top bit clear.
- R3: Repeated values give the correct fifth-ranked result. This covers a group of nine equal values and groups with only two or three distinct values.
- R4: `out_valid` rises exactly L cycles after the clock edge that captures a group with `in_valid` high. L is the number of set bits in `REG_MASK` (9 by default). `out_median` at that time belongs to that group.
- R5: A new group can be accepted on every clock. Back-to-back groups each produce their own result on consecutive cycles.
- R6: A cycle with `in_valid` low never produces a result. Whatever is on `in_pix` during such a cycle has no effect on any reported median, and gaps in the input reappear unchanged at the output.
- R7: A synchronous active-low reset clears every valid bit in the pipeline. `out_valid` is low while reset is held. Groups that were in flight when reset was applied never appear at the output.
- R8: The result does not depend on which input position holds which value. Any permutation of a group yields the same median.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset, clears valid bits |
| in_valid | input | 1 | Marks `in_pix` as a group to process |
| in_pix | input | 9*DATA_W | Nine packed pixels, pixel k at bits [k*DATA_W +: DATA_W] |
| out_valid | output | 1 | Marks `out_median` as a result |
| out_median | output | DATA_W | Fifth-ranked pixel of the group |

## Verification
The ordering is swept over all 19683 groups built from three levels (3, 128 and 250) placed in every position. This sweep covers every mix of ties and every placement of the high-bit values, so it exposes an unsigned-compare error, a missing or swapped compare-exchange cell, or a bad tie rule. Directed groups add ascending, descending, all-equal and rotated inputs, so a lane wired to the wrong position shows up. A long pseudo-random stream with random gaps, plus fully back-to-back bursts, tells a correct latency and gap pattern apart from dropped, duplicated or shifted results. A reset applied while the pipeline is full checks that in-flight groups are discarded.

// File: rtl/median9_pkg.sv
package median9_pkg;

   localparam int N_PIX    = 9;
   localparam int N_STAGES = 9;
   localparam int N_SLOTS  = 3;
   localparam int MED_IDX  = 4;

   // Compare-exchange schedule: returns {lo_lane, hi_lane}; 8'hFF marks an empty slot.
   // After the cell, the smaller value sits on lo_lane and the larger on hi_lane.
   function automatic logic [7:0] cx_pair(input int stage, input int slot);
      case (stage * N_SLOTS + slot)
         0:       return 8'h12;
         1:       return 8'h45;
         2:       return 8'h78;
         3:       return 8'h01;
         4:       return 8'h34;
         5:       return 8'h67;
         6:       return 8'h12;
         7:       return 8'h45;
         8:       return 8'h78;
         9:       return 8'h03;
         10:      return 8'h58;
         11:      return 8'h47;
         12:      return 8'h36;
         13:      return 8'h14;
         14:      return 8'h25;
         15:      return 8'h47;
         18:      return 8'h42;
         21:      return 8'h64;
         24:      return 8'h42;
         default: return 8'hFF;
      endcase
   endfunction

endpackage

// File: rtl/median9_cx.sv
module median9_cx #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] lo,
   output logic [W-1:0] hi
);

   logic swap;

   assign swap = (a > b);
   assign lo   = swap ? b : a;
   assign hi   = swap ? a : b;

   always_comb begin
      // R1
      cx_order_chk: assert (lo <= hi && ((lo == a && hi == b) || (lo == b && hi == a)));
   end

endmodule

// File: rtl/median9_stage.sv
module median9_stage
   import median9_pkg::*;
#(
   parameter int W          = 8,
   parameter int STAGE      = 0,
   parameter bit REGISTERED = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               vld_i,
   input  logic [N_PIX*W-1:0] pix_i,
   output logic               vld_o,
   output logic [N_PIX*W-1:0] pix_o
);

   logic [W-1:0]       cur [N_PIX];
   logic [W-1:0]       nxt [N_PIX];
   logic [W-1:0]       mn  [N_SLOTS];
   logic [W-1:0]       mx  [N_SLOTS];
   logic [N_PIX*W-1:0] nxt_flat;

   genvar i, sl;

   generate
      for (i = 0; i < N_PIX; i++) begin : g_lane
         assign cur[i]             = pix_i[i*W +: W];
         assign nxt_flat[i*W +: W] = nxt[i];
      end

      for (sl = 0; sl < N_SLOTS; sl++) begin : g_slot
         localparam logic [7:0] PR = cx_pair(STAGE, sl);
         if (PR != 8'hFF) begin : g_cell
            median9_cx #(.W(W)) u_cx (
               .a  (cur[PR[7:4]]),
               .b  (cur[PR[3:0]]),
               .lo (mn[sl]),
               .hi (mx[sl])
            );
         end else begin : g_empty
            assign mn[sl] = '0;
            assign mx[sl] = '0;
         end
      end
   endgenerate

   always_comb begin
      logic [7:0] pr;
      for (int k = 0; k < N_PIX; k++) nxt[k] = cur[k];
      for (int s = 0; s < N_SLOTS; s++) begin
         pr = cx_pair(STAGE, s);
         if (pr != 8'hFF) begin
            nxt[pr[7:4]] = mn[s];
            nxt[pr[3:0]] = mx[s];
         end
      end
   end

   generate
      if (REGISTERED) begin : g_reg
         logic               vld_q;
         logic [N_PIX*W-1:0] pix_q;

         always_ff @(posedge clk) begin
            if (!rst_n) vld_q <= 1'b0;
            else        vld_q <= vld_i;
            if (vld_i)  pix_q <= nxt_flat;
         end

         assign vld_o = vld_q;
         assign pix_o = pix_q;

         // R4
         valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            vld_i |=> vld_o);
         // R6
         no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !vld_i |=> !vld_o);
         // R7
         reset_clear_chk: assert property (@(posedge clk)
            !rst_n |=> !vld_o);
      end else begin : g_comb
         assign vld_o = vld_i;
         assign pix_o = nxt_flat;
      end
   endgenerate

endmodule

// File: rtl/median9_sorter.sv
module median9_sorter
   import median9_pkg::*;
#(
   parameter int                  DATA_W   = 8,
   parameter logic [N_STAGES-1:0] REG_MASK = '1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [N_PIX*DATA_W-1:0] in_pix,
   output logic                    out_valid,
   output logic [DATA_W-1:0]       out_median
);

   localparam int BUS_W = N_PIX * DATA_W;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("median9_sorter: DATA_W must be at least 1");
      end
      if (MED_IDX >= N_PIX) begin : g_bad_index
         $error("median9_sorter: median lane outside the pixel set");
      end
   endgenerate

   logic             vld_c [N_STAGES+1];
   logic [BUS_W-1:0] pix_c [N_STAGES+1];

   assign vld_c[0] = in_valid;
   assign pix_c[0] = in_pix;

   genvar st;
   generate
      for (st = 0; st < N_STAGES; st++) begin : g_stage
         median9_stage #(
            .W          (DATA_W),
            .STAGE      (st),
            .REGISTERED (REG_MASK[st])
         ) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .vld_i (vld_c[st]),
            .pix_i (pix_c[st]),
            .vld_o (vld_c[st+1]),
            .pix_o (pix_c[st+1])
         );
      end
   endgenerate

   assign out_valid  = vld_c[N_STAGES];
   assign out_median = pix_c[N_STAGES][MED_IDX*DATA_W +: DATA_W];

   // Rank check: the final lanes are a permutation of the group, so the centre
   // lane must have at least five lanes at or below it and five at or above it.
   int cnt_le;
   int cnt_ge;

   always_comb begin
      cnt_le = 0;
      cnt_ge = 0;
      for (int k = 0; k < N_PIX; k++) begin
         if (pix_c[N_STAGES][k*DATA_W +: DATA_W] <= out_median) cnt_le++;
         if (pix_c[N_STAGES][k*DATA_W +: DATA_W] >= out_median) cnt_ge++;
      end
   end

   // R1
   median_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (cnt_le >= MED_IDX + 1 && cnt_ge >= N_PIX - MED_IDX));

endmodule

// File: tb/median9_sorter_bench.sv
`timescale 1ns/1ps
module median9_sorter_bench;

   localparam int LAT  = 9;
   localparam int RING = 4096;

   typedef logic [8:0][7:0] grp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [71:0] in_pix = '0;
   logic        out_valid;
   logic [7:0]  out_median;

   median9_sorter u_median9_sorter (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_pix     (in_pix),
      .out_valid  (out_valid),
      .out_median (out_median)
   );

   always #4 clk = ~clk;

   int          cyc = 0;
   int          n_chk = 0;
   int          n_bad = 0;
   logic        hv [RING];
   logic [7:0]  hm [RING];
   string       tag = "R7";
   logic [31:0] seed = 32'h1234_5678;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [7:0] med_ref(input grp_t g);
      logic [7:0] a [9];
      logic [7:0] t;
      for (int k = 0; k < 9; k++) a[k] = g[k];
      for (int x = 0; x < 9; x++)
         for (int y = 0; y < 8 - x; y++)
            if (a[y] > a[y+1]) begin
               t = a[y]; a[y] = a[y+1]; a[y+1] = t;
            end
      return a[4];
   endfunction

   task automatic next_rand(output logic [31:0] r);
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      r = seed;
   endtask

   task automatic check_out();
      int   p;
      logic ev;
      logic [7:0] em;
      string t;
      p  = cyc;
      t  = rst_n ? tag : "R7";
      ev = 1'b0;
      em = '0;
      if (p >= LAT) begin
         ev = hv[(p - LAT + 1) % RING];
         em = hm[(p - LAT + 1) % RING];
      end
      n_chk++;
      if (out_valid !== ev) begin
         n_bad++;
         $display("FAIL %s out_valid at cycle %0d: got %0b expected %0b", t, p, out_valid, ev);
      end
      if (ev) begin
         n_chk++;
         if (out_median !== em) begin
            n_bad++;
            $display("FAIL %s out_median at cycle %0d: got %0d expected %0d", t, p, out_median, em);
         end
      end
   endtask

   task automatic step(input logic v, input grp_t g, input logic r);
      int idx;
      @(negedge clk);
      check_out();
      in_valid = v;
      in_pix   = g;
      rst_n    = r;
      idx      = (cyc + 1) % RING;
      hv[idx]  = v && r;
      hm[idx]  = med_ref(g);
      if (!r)
         for (int k = 0; k < LAT; k++) hv[(cyc + 1 - k + RING) % RING] = 1'b0;
   endtask

   task automatic rand_grp(output grp_t g);
      logic [31:0] r0, r1, r2;
      next_rand(r0); next_rand(r1); next_rand(r2);
      g = {r2[7:0], r1[31:0], r0[31:0]};
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      grp_t g;
      logic [31:0] r;
      for (int k = 0; k < RING; k++) begin hv[k] = 1'b0; hm[k] = '0; end

      // R7: reset state, out_valid low while reset held
      tag = "R7";
      for (int k = 0; k < 4; k++) step(1'b1, '1, 1'b0);

      // R1: ascending and descending groups
      tag = "R1";
      for (int k = 0; k < 9; k++) g[k] = 8'(k * 10 + 3);
      step(1'b1, g, 1'b1);
      for (int k = 0; k < 9; k++) g[k] = 8'(200 - k * 7);
      step(1'b1, g, 1'b1);

      // R3: all equal, then few distinct values
      tag = "R3";
      for (int k = 0; k < 9; k++) g[k] = 8'd77;
      step(1'b1, g, 1'b1);
      for (int k = 0; k < 9; k++) g[k] = (k < 4) ? 8'd5 : 8'd9;
      step(1'b1, g, 1'b1);
      for (int k = 0; k < 9; k++) g[k] = (k < 5) ? 8'd5 : 8'd9;
      step(1'b1, g, 1'b1);

      // R2: high-bit values must order above low ones
      tag = "R2";
      for (int k = 0; k < 9; k++) g[k] = (k == 8) ? 8'd128 : ((k % 2 == 0) ? 8'd255 : 8'd0);
      step(1'b1, g, 1'b1);
      for (int k = 0; k < 9; k++) g[k] = (k < 4) ? 8'd127 : 8'd129;
      step(1'b1, g, 1'b1);

      // R8: rotations of one group, all must give 50
      tag = "R8";
      for (int rot = 0; rot < 9; rot++) begin
         for (int k = 0; k < 9; k++) g[k] = 8'(((k + rot) % 9) * 10 + 10);
         step(1'b1, g, 1'b1);
      end

      // R5: back-to-back random groups
      tag = "R5";
      for (int k = 0; k < 40; k++) begin rand_grp(g); step(1'b1, g, 1'b1); end

      // R6: alternating gaps with junk on the bus
      tag = "R6";
      for (int k = 0; k < 40; k++) begin rand_grp(g); step(k[0], g, 1'b1); end
      for (int k = 0; k < 12; k++) begin rand_grp(g); step(1'b0, g, 1'b1); end

      // R4: long random stream with random gaps
      tag = "R4";
      for (int k = 0; k < 3000; k++) begin
         rand_grp(g);
         next_rand(r);
         step(r[1:0] != 2'b00, g, 1'b1);
      end

      // R7: reset while the pipeline is full drops in-flight groups
      tag = "R7";
      for (int k = 0; k < 6; k++) begin rand_grp(g); step(1'b1, g, 1'b1); end
      rand_grp(g); step(1'b1, g, 1'b0);
      for (int k = 0; k < 12; k++) begin rand_grp(g); step(k < 3, g, 1'b1); end

      // R3: three-level exhaustive sweep over every position
      tag = "R3";
      for (int n = 0; n < 19683; n++) begin
         int q;
         q = n;
         for (int k = 0; k < 9; k++) begin
            g[k] = (q % 3 == 0) ? 8'd3 : ((q % 3 == 1) ? 8'd128 : 8'd250);
            q = q / 3;
         end
         step(1'b1, g, 1'b1);
      end

      tag = "R6";
      for (int k = 0; k < LAT + 3; k++) step(1'b0, '0, 1'b1);

      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      summary();
      $finish;
   end

endmodule